// File: doc/BRIEF.md
# Adjacent-Pixel Cluster Trigger

This block watches the discriminator lines of an 8x8 pixel module. Every line belongs to one pixel and goes high when that pixel's fast-shaped signal crosses its threshold. The lines arrive together and have no relation to the block clock. The block raises a single-cycle module trigger when some group of mutually adjacent active pixels is at least a chosen size. Such a group may sit anywhere in the matrix. A simple OR of the lines, or a pixel count, would trigger on scattered noise hits. Requiring a connected cluster rejects those.

Each line passes through a two-flop synchronizer. It is then stretched so that it stays active for a programmable window of 1 to 8 cycles after it was last seen high. Pixels that fire a few cycles apart can therefore count as coincident. The connectivity search works on each active pixel in turn. It grows a region from that pixel through active neighbours for up to MAX_SIZE-1 steps. It then asks whether any such region holds enough pixels. A parameter chooses between orthogonal and eight-way adjacency.

All inputs are plain level signals with no handshake. The hit lines are sampled every cycle and cannot be held off. The size and window inputs are expected to be static while a trigger is being formed. The trigger output is a one-cycle pulse with no acknowledge.

Top module: `clump_trig`

## Requirements
- R1: The trigger latency is fixed. A qualifying pattern that is first present on `hit_i` at a rising edge produces `trig_o` high for the single cycle that follows the fifth rising edge after it.
- R2: Pixel index is row*8+column. With DIAG=0, two pixels are adjacent only when they share a row and their columns differ by one, or share a column and their rows differ by one. Adjacency never wraps from the end of one row to the start of the next.
- R3: With DIAG=1, pixels that touch only diagonally are also adjacent.
- R4: A trigger needs a connected group of at least N active pixels. N is `min_size_i`, with values below 2 treated as 2 and values above 8 treated as 8.
- R5: A qualifying group triggers wherever it lies, including along the edges and in the corners of the matrix.
- R6: A pixel sampled high stays active for `win_i`+1 cycles. Hits on different cycles are combined when their separation in cycles is at most `win_i`.
- R7: Each rising of the cluster condition gives exactly one one-cycle pulse. No further pulse comes while the condition stays true.
- R8: When `en_i` is low, no pulse is produced.
- R9: During reset and on leaving it, `trig_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Trigger enable |
| min_size_i | input | 4 | Minimum cluster size, clamped to 2..8 |
| win_i | input | 3 | Coincidence window minus one, in cycles |
| hit_i | input | 64 | Asynchronous discriminator lines, bit row*8+column |
| trig_o | output | 1 | Module trigger pulse |

## Verification
The bench builds two copies of the block with the default 8x8 geometry and MAX_SIZE of 8. One copy has DIAG=0 and the other DIAG=1, and both see the same stimulus. A diagonal-only cluster therefore triggers exactly one of them. The row-end wrap case, corner clusters and random sparse patterns are judged against a flood-fill model for both adjacency rules. The size and window inputs are changed at run time so that both clamp limits and both sides of the coincidence boundary are reached.

// File: rtl/ctrig_pkg.sv
package ctrig_pkg;
  // Clamp a requested cluster size into the supported range.
  function automatic int unsigned clamp_size(input int unsigned req, input int unsigned hi);
    if (req < 2) return 2;
    if (req > hi) return hi;
    return req;
  endfunction
endpackage

// File: rtl/ctrig_front.sv
module ctrig_front #(
  parameter int NPIX = 64,
  parameter int WIN_MAX = 8,
  localparam int WW = $clog2(WIN_MAX),
  localparam int CW = $clog2(WIN_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [WW-1:0]   win_i,
  input  logic [NPIX-1:0] hit_i,
  output logic [NPIX-1:0] act_o
);
  logic [CW-1:0] load;
  assign load = CW'(win_i) + CW'(1);

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic          s1, s2;
    logic [CW-1:0] cnt;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1  <= 1'b0;
        s2  <= 1'b0;
        cnt <= '0;
      end else begin
        s1 <= hit_i[p];
        s2 <= s1;
        if (s2)              cnt <= load;
        else if (cnt != '0)  cnt <= cnt - CW'(1);
      end
    end
    assign act_o[p] = (cnt != '0);
  end
endmodule

// File: rtl/ctrig_grow.sv
module ctrig_grow #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DIAG = 0,
  parameter int MAX_SIZE = 8,
  localparam int NPIX = ROWS * COLS,
  localparam int SZW = $clog2(MAX_SIZE + 1),
  localparam int CNTW = $clog2(NPIX + 1),
  localparam int REACH = MAX_SIZE - 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIX-1:0] act_i,
  input  logic [SZW-1:0]  thr_i,
  output logic            found_o
);
  function automatic logic [NPIX-1:0] col_mask(input int c);
    logic [NPIX-1:0] m;
    for (int i = 0; i < NPIX; i++) m[i] = ((i % COLS) == c);
    return m;
  endfunction

  localparam logic [NPIX-1:0] FIRST_COL = col_mask(0);
  localparam logic [NPIX-1:0] LAST_COL  = col_mask(COLS - 1);

  // One step of region growth: every pixel next to the region.
  function automatic logic [NPIX-1:0] spread(input logic [NPIX-1:0] m);
    logic [NPIX-1:0] d;
    d = m | ((m << 1) & ~FIRST_COL) | ((m >> 1) & ~LAST_COL)
          | (m << COLS) | (m >> COLS);
    if (DIAG != 0)
      d = d | ((m << (COLS + 1)) & ~FIRST_COL) | ((m << (COLS - 1)) & ~LAST_COL)
            | ((m >> (COLS - 1)) & ~FIRST_COL) | ((m >> (COLS + 1)) & ~LAST_COL);
    return d;
  endfunction

  logic [NPIX-1:0] seed_ok;

  for (genvar s = 0; s < NPIX; s++) begin : g_seed
    logic [NPIX-1:0] ball;
    logic [CNTW-1:0] cnt;
    always_comb begin
      ball    = '0;
      ball[s] = act_i[s];
      for (int it = 0; it < REACH; it++) ball = ball | (spread(ball) & act_i);
      cnt        = CNTW'($countones(ball));
      seed_ok[s] = (cnt >= CNTW'(thr_i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) found_o <= 1'b0;
    else         found_o <= |seed_ok;
  end
endmodule

// File: rtl/ctrig_pulse.sv
module ctrig_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic found_i,
  output logic trig_o
);
  logic found_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_d <= 1'b0;
      trig_o  <= 1'b0;
    end else begin
      found_d <= found_i;
      trig_o  <= en_i & found_i & ~found_d;
    end
  end
endmodule

// File: rtl/clump_trig.sv
module clump_trig #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DIAG = 0,
  parameter int MAX_SIZE = 8,
  parameter int WIN_MAX = 8,
  localparam int NPIX = ROWS * COLS,
  localparam int SZW = $clog2(MAX_SIZE + 1),
  localparam int WW = $clog2(WIN_MAX)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [SZW-1:0]  min_size_i,
  input  logic [WW-1:0]   win_i,
  input  logic [NPIX-1:0] hit_i,
  output logic            trig_o
);
  logic [NPIX-1:0] act;
  logic [SZW-1:0]  thr;
  logic            found;

  assign thr = SZW'(ctrig_pkg::clamp_size(32'(min_size_i), MAX_SIZE));

  ctrig_front #(.NPIX(NPIX), .WIN_MAX(WIN_MAX)) u_front (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_i(win_i), .hit_i(hit_i), .act_o(act)
  );

  ctrig_grow #(.ROWS(ROWS), .COLS(COLS), .DIAG(DIAG), .MAX_SIZE(MAX_SIZE)) u_grow (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .thr_i(thr), .found_o(found)
  );

  ctrig_pulse u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .found_i(found), .trig_o(trig_o)
  );
endmodule

// File: rtl/ctrig_chk.sv
module ctrig_chk #(
  parameter int NPIX = 64,
  parameter int SZW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            en_i,
  input logic            trig_o,
  input logic [NPIX-1:0] act,
  input logic            found,
  input logic [SZW-1:0]  thr
);
  p_one_cycle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_trig_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(found));

  p_en_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !trig_o);

  p_size_floor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> ($countones($past(act)) >= $past(thr)));

  p_no_act_no_found_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == '0) |=> !found);

  always @(posedge clk_i)
    if (!rst_ni) p_reset_low_r9: assert (!trig_o);
endmodule

bind clump_trig ctrig_chk #(.NPIX(NPIX), .SZW(SZW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .trig_o(trig_o),
  .act(act), .found(found), .thr(thr)
);

// File: tb/sim_clump_trig.sv
module sim_clump_trig;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        en;
  logic [3:0]  msz;
  logic [2:0]  win;
  logic [63:0] hit;
  logic        trig0, trig1;

  clump_trig #(.DIAG(0)) u0 (.clk_i(clk), .rst_ni(rst_n), .en_i(en), .min_size_i(msz),
                             .win_i(win), .hit_i(hit), .trig_o(trig0));
  clump_trig #(.DIAG(1)) u1 (.clk_i(clk), .rst_ni(rst_n), .en_i(en), .min_size_i(msz),
                             .win_i(win), .hit_i(hit), .trig_o(trig1));

  int cyc = 0, checks = 0, errors = 0;
  int pulses0 = 0, pulses1 = 0;
  int q0[$], q1[$];
  bit live = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent model: largest connected group by flood fill.
  function automatic int maxcomp(input logic [63:0] m, input bit diag);
    int best = 0;
    bit seen[64];
    int stk[64];
    int sp, n, p, r, c, q;
    foreach (seen[i]) seen[i] = 0;
    for (int s = 0; s < 64; s++) begin
      if (m[s] && !seen[s]) begin
        sp = 1; stk[0] = s; seen[s] = 1; n = 0;
        while (sp > 0) begin
          sp--; p = stk[sp]; n++;
          r = p / 8; c = p % 8;
          for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
              if ((dr != 0 || dc != 0) && (diag || dr == 0 || dc == 0) &&
                  r + dr >= 0 && r + dr < 8 && c + dc >= 0 && c + dc < 8) begin
                q = (r + dr) * 8 + c + dc;
                if (m[q] && !seen[q]) begin
                  seen[q] = 1; stk[sp] = q; sp++;
                end
              end
        end
        if (n > best) best = n;
      end
    end
    return best;
  endfunction

  function automatic int thr_of(input int v);
    return (v < 2) ? 2 : (v > 8) ? 8 : v;
  endfunction

  function automatic logic [63:0] px(input int r, input int c);
    return 64'd1 << (r * 8 + c);
  endfunction

  // Monitors: every pulse must match the head of the expected queue (R1).
  always @(negedge clk) if (live) begin
    if (trig0) begin
      pulses0++;
      check(q0.size() > 0 && q0[0] == cyc, "R1", "dut4 pulse cycle", cyc,
            (q0.size() > 0) ? q0[0] : -1);
      if (q0.size() > 0 && q0[0] == cyc) void'(q0.pop_front());
    end else if (q0.size() > 0 && q0[0] < cyc) begin
      check(1'b0, "R1", "dut4 missing pulse", cyc, q0[0]);
      void'(q0.pop_front());
    end
  end

  always @(negedge clk) if (live) begin
    if (trig1) begin
      pulses1++;
      check(q1.size() > 0 && q1[0] == cyc, "R1", "dut8 pulse cycle", cyc,
            (q1.size() > 0) ? q1[0] : -1);
      if (q1.size() > 0 && q1[0] == cyc) void'(q1.pop_front());
    end else if (q1.size() > 0 && q1[0] < cyc) begin
      check(1'b0, "R1", "dut8 missing pulse", cyc, q1[0]);
      void'(q1.pop_front());
    end
  end

  task automatic settle(input string req, input int b0, input int b1,
                        input int e0, input int e1);
    repeat (20) @(negedge clk);
    check(pulses0 - b0 == e0, req, "dut4 pulse count", pulses0 - b0, e0);
    check(pulses1 - b1 == e1, req, "dut8 pulse count", pulses1 - b1, e1);
  endtask

  // Driver: present one pattern for hold cycles and queue the expected pulse.
  task automatic shot(input logic [63:0] p, input int hold, input string req);
    int k, e0, e1;
    int b0 = pulses0;
    int b1 = pulses1;
    @(negedge clk);
    k = cyc; hit = p;
    e0 = (en && maxcomp(p, 0) >= thr_of(msz)) ? 1 : 0;
    e1 = (en && maxcomp(p, 1) >= thr_of(msz)) ? 1 : 0;
    if (e0 != 0) q0.push_back(k + 5);
    if (e1 != 0) q1.push_back(k + 5);
    repeat (hold) @(negedge clk);
    hit = '0;
    settle(req, b0, b1, e0, e1);
  endtask

  // Two single-cycle hits d cycles apart; each part alone is below threshold.
  task automatic pair(input logic [63:0] a, input logic [63:0] b, input int d,
                      input string req);
    int k, e0, e1;
    int b0 = pulses0;
    int b1 = pulses1;
    @(negedge clk);
    k = cyc; hit = a;
    @(negedge clk); hit = '0;
    repeat (d - 1) @(negedge clk);
    hit = b;
    e0 = (en && d <= int'(win) && maxcomp(a | b, 0) >= thr_of(msz)) ? 1 : 0;
    e1 = (en && d <= int'(win) && maxcomp(a | b, 1) >= thr_of(msz)) ? 1 : 0;
    if (e0 != 0) q0.push_back(k + d + 5);
    if (e1 != 0) q1.push_back(k + d + 5);
    @(negedge clk); hit = '0;
    settle(req, b0, b1, e0, e1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: got %0d cycles expected completion", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] p, a, b;
    rst_n = 1'b0; en = 1'b1; msz = 4'd5; win = 3'd0; hit = '0;
    repeat (3) @(negedge clk);
    check(trig0 == 1'b0 && trig1 == 1'b0, "R9", "trig during reset", trig0 | trig1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(trig0 == 1'b0 && trig1 == 1'b0, "R9", "trig after reset", trig0 | trig1, 0);
    live = 1;

    // R1 R2: five in a row, both adjacency rules fire.
    p = '0; for (int c = 0; c < 5; c++) p |= px(0, c);
    shot(p, 1, "R2");
    // R4: four only.
    p = '0; for (int c = 2; c < 6; c++) p |= px(2, c);
    shot(p, 1, "R4");
    // R3: diagonal line fires only the eight-way copy.
    p = '0; for (int i = 0; i < 5; i++) p |= px(i, i);
    shot(p, 1, "R3");
    // R2: row end must not join the next row start.
    p = px(0, 5) | px(0, 6) | px(0, 7) | px(1, 0) | px(1, 1);
    shot(p, 1, "R2");
    // R5: corner block.
    p = px(6, 5) | px(6, 6) | px(6, 7) | px(7, 5) | px(7, 6) | px(7, 7);
    shot(p, 2, "R5");
    // R4: size limits and clamping.
    msz = 4'd8;
    p = '0; for (int r = 0; r < 7; r++) p |= px(r, 7);
    shot(p, 1, "R4");
    p |= px(7, 7);
    shot(p, 1, "R4");
    msz = 4'd15;
    shot(p & ~px(0, 7), 1, "R4");
    msz = 4'd0;
    shot(px(4, 4), 1, "R4");
    shot(px(4, 4) | px(4, 3), 1, "R4");
    // R7: held cluster gives a single pulse.
    msz = 4'd5;
    p = '0; for (int c = 1; c < 6; c++) p |= px(5, c);
    shot(p, 30, "R7");
    // R8: disabled.
    en = 1'b0;
    shot(p, 3, "R8");
    en = 1'b1;
    // R6: coincidence window.
    a = px(3, 0) | px(3, 1) | px(3, 2);
    b = px(3, 3) | px(3, 4);
    win = 3'd0; pair(a, b, 1, "R6");
    win = 3'd3; pair(a, b, 3, "R6");
    pair(a, b, 4, "R6");
    win = 3'd7; pair(a, b, 7, "R6");
    // R2 R3 R4: random sparse patterns against the flood-fill model.
    win = 3'd0;
    for (int n = 0; n < 40; n++) begin
      msz = 4'($urandom_range(2, 8));
      p = {$urandom, $urandom} & ({$urandom, $urandom} | {$urandom, $urandom});
      shot(p, 1, "R4");
    end

    live = 0;
    check(q0.size() == 0 && q1.size() == 0, "R1", "leftover expected pulses",
          q0.size() + q1.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule